// File: doc/BRIEF.md
# Channel Protection Register Bank

This block keeps the protection state for one group of six high-voltage channels. For each channel it holds three bits: an over-voltage flag, an over-current flag and an inhibit bit. From these it drives one disable line and one current-limit line per channel. Digital trip inputs from the analog limit comparators set the flags. A controller command port can set or clear the flags, or inhibit or enable channels. Each command acts on one addressed channel or on every channel at once.

A static mode input chooses what an over-current does. When the input is low, the channel is turned off. When it is high, the channel stays on and is held at its current limit. An over-voltage always turns the channel off. A selection input picks one channel out of a two-group address space. For that channel the block returns its voltage and current protection status. When the selected channel belongs to the other group, the status bits arriving from that group are passed through instead. All outputs are registered, and each one shows the state that results from the same clock edge.

Top module: `prot_bank`

## Requirements
- R1: With `rst` high at a clock edge, all flags clear, every inhibit bit sets, every `chan_off_o` bit reads 1, and `ilim_o`, `vsel_o` and `csel_o` read 0 after that edge.
- R2: A high `vtrip_i[i]` sampled at an edge sets the channel-i voltage flag, and `chan_off_o[i]` is 1 after that same edge. The flag stays set until a clear command reaches it.
- R3: A high `ctrip_i[i]` sets the channel-i current flag. With `cc_hold_i`=0 the channel turns off. With `cc_hold_i`=1 and no other cause to turn off, `chan_off_o[i]`=0 and `ilim_o[i]`=1.
- R4: When `cmd_valid_i`=1 and `cmd_all_i`=0, the command acts only on channel `cmd_chan_i`. Op codes on `cmd_op_i`: 2'b00 clears both protection flags, 2'b01 sets both protection flags, 2'b10 clears the inhibit bit, and 2'b11 sets the inhibit bit.
- R5: When `cmd_valid_i`=1 and `cmd_all_i`=1, the command acts on all six channels regardless of `cmd_chan_i`.
- R6: A trip input that is high in the same cycle as a clear command for that channel leaves the matching flag set.
- R7: `chan_off_o[i]` is the OR of the inhibit bit, the voltage flag and, when `cc_hold_i`=0, the current flag. `ilim_o[i]` is 1 only when the current flag is set and the channel is not off.
- R8: `cc_hold_i` is sampled at every edge. A change in it while a current flag is set shows on `chan_off_o` and `ilim_o` after the next edge.
- R9: For `sel_chan_i` in 0..5, `vsel_o` and `csel_o` give the voltage and current flags of that local channel.
- R10: For `sel_chan_i` in 6..11, `vsel_o` and `csel_o` equal `rmt_vprot_i` and `rmt_cprot_i` as sampled at the same edge. For `sel_chan_i` of 12 or more, both read 0.
- R11: A single-channel command with `cmd_chan_i` of 6 or more leaves every local flag and inhibit bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| vtrip_i | input | 6 | Over-voltage trip, one per local channel |
| ctrip_i | input | 6 | Over-current trip, one per local channel |
| cc_hold_i | input | 1 | Over-current response: 1 holds the channel at its limit, 0 turns it off |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 2 | Command op code (see R4) |
| cmd_all_i | input | 1 | Command applies to every channel |
| cmd_chan_i | input | 4 | Command channel address |
| sel_chan_i | input | 4 | Channel whose status is returned |
| rmt_vprot_i | input | 1 | Voltage protection status from the other group |
| rmt_cprot_i | input | 1 | Current protection status from the other group |
| chan_off_o | output | 6 | Channel disable |
| ilim_o | output | 6 | Channel held at its current limit |
| vsel_o | output | 1 | Voltage protection status of the selected channel |
| csel_o | output | 1 | Current protection status of the selected channel |

## Verification
The assertions assume that a command strobe lasts exactly one cycle. They also assume that every input is steady around the sampling edge, and that the remote status bits only matter while a remote channel is selected. The stimulus drives every input on the falling edge and raises the command strobe for one clocked step at a time. It changes the mode input only between steps. Trip pulses last one step, so the sticky behaviour of the flags can be seen with the comparators quiet.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [1:0] {
    OP_CLR_PROT = 2'b00,
    OP_SET_PROT = 2'b01,
    OP_ENABLE   = 2'b10,
    OP_INHIBIT  = 2'b11
  } prot_op_e;
endpackage

// File: rtl/prot_cmd_decode.sv
module prot_cmd_decode
  import prot_pkg::*;
#(
  parameter int N_CH   = 6,
  parameter int ADDR_W = 4
) (
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_all_i,
  input  logic [ADDR_W-1:0] cmd_chan_i,
  output logic [N_CH-1:0]   set_m_o,
  output logic [N_CH-1:0]   clr_m_o,
  output logic [N_CH-1:0]   inh_m_o,
  output logic [N_CH-1:0]   en_m_o
);
  prot_op_e op;
  assign op = prot_op_e'(cmd_op_i);

  for (genvar i = 0; i < N_CH; i++) begin : g_hit
    logic hit;
    assign hit        = cmd_valid_i && (cmd_all_i || (cmd_chan_i == ADDR_W'(i)));
    assign set_m_o[i] = hit && (op == OP_SET_PROT);
    assign clr_m_o[i] = hit && (op == OP_CLR_PROT);
    assign inh_m_o[i] = hit && (op == OP_INHIBIT);
    assign en_m_o[i]  = hit && (op == OP_ENABLE);
  end
endmodule

// File: rtl/prot_chan_slice.sv
module prot_chan_slice (
  input  logic clk,
  input  logic rst,
  input  logic vtrip_i,
  input  logic ctrip_i,
  input  logic cc_hold_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic inh_i,
  input  logic en_i,
  output logic vflag_n_o,
  output logic cflag_n_o,
  output logic chan_off_o,
  output logic ilim_o
);
  logic vflag_q, cflag_q, inh_q;
  logic inh_n, off_n;

  // a live trip wins over a clear arriving in the same cycle
  assign vflag_n_o = (vflag_q & ~clr_i) | set_i | vtrip_i;
  assign cflag_n_o = (cflag_q & ~clr_i) | set_i | ctrip_i;
  assign inh_n     = (inh_q & ~en_i) | inh_i;
  assign off_n     = inh_n | vflag_n_o | (cflag_n_o & ~cc_hold_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      vflag_q    <= 1'b0;
      cflag_q    <= 1'b0;
      inh_q      <= 1'b1;
      chan_off_o <= 1'b1;
      ilim_o     <= 1'b0;
    end else begin
      vflag_q    <= vflag_n_o;
      cflag_q    <= cflag_n_o;
      inh_q      <= inh_n;
      chan_off_o <= off_n;
      ilim_o     <= cflag_n_o & ~off_n;
    end
  end

  p_vtrip_off_r2: assert property (@(posedge clk) disable iff (rst)
    vtrip_i |=> (chan_off_o && vflag_q));
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (vflag_q && !clr_i) |=> vflag_q);
  p_kill_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrip_i && !cc_hold_i) |=> chan_off_o);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrip_i && cc_hold_i) |=> (chan_off_o || ilim_o));
  p_trip_beats_clr_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && ctrip_i) |=> cflag_q);
  p_flag_off_r7: assert property (@(posedge clk) disable iff (rst)
    (vflag_q || inh_q) |-> chan_off_o);
  p_ilim_flag_r7: assert property (@(posedge clk) disable iff (rst)
    ilim_o |-> (cflag_q && !chan_off_o));
endmodule

// File: rtl/prot_status_mux.sv
module prot_status_mux #(
  parameter int N_CH   = 6,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sel_chan_i,
  input  logic [N_CH-1:0]   vflags_n_i,
  input  logic [N_CH-1:0]   cflags_n_i,
  input  logic              rmt_vprot_i,
  input  logic              rmt_cprot_i,
  output logic              vsel_o,
  output logic              csel_o
);
  localparam logic [ADDR_W-1:0] RMT_LO = ADDR_W'(N_CH);
  localparam logic [ADDR_W-1:0] RMT_HI = ADDR_W'(2 * N_CH - 1);

  logic is_rmt;
  logic v_loc, c_loc;

  assign is_rmt = (sel_chan_i >= RMT_LO) && (sel_chan_i <= RMT_HI);

  always_comb begin
    v_loc = 1'b0;
    c_loc = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      if (sel_chan_i == ADDR_W'(i)) begin
        v_loc = vflags_n_i[i];
        c_loc = cflags_n_i[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vsel_o <= 1'b0;
      csel_o <= 1'b0;
    end else if (is_rmt) begin
      vsel_o <= rmt_vprot_i;
      csel_o <= rmt_cprot_i;
    end else begin
      vsel_o <= v_loc;
      csel_o <= c_loc;
    end
  end

  p_remote_pass_r10: assert property (@(posedge clk) disable iff (rst)
    is_rmt |=> (vsel_o == $past(rmt_vprot_i) && csel_o == $past(rmt_cprot_i)));
  p_out_of_range_r10: assert property (@(posedge clk) disable iff (rst)
    (sel_chan_i > RMT_HI) |=> (!vsel_o && !csel_o));
endmodule

// File: rtl/prot_bank.sv
module prot_bank
  import prot_pkg::*;
#(
  parameter int N_CH   = 6,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   vtrip_i,
  input  logic [N_CH-1:0]   ctrip_i,
  input  logic              cc_hold_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_all_i,
  input  logic [ADDR_W-1:0] cmd_chan_i,
  input  logic [ADDR_W-1:0] sel_chan_i,
  input  logic              rmt_vprot_i,
  input  logic              rmt_cprot_i,
  output logic [N_CH-1:0]   chan_off_o,
  output logic [N_CH-1:0]   ilim_o,
  output logic              vsel_o,
  output logic              csel_o
);
  logic [N_CH-1:0] set_m, clr_m, inh_m, en_m;
  logic [N_CH-1:0] vflags_n, cflags_n;

  prot_cmd_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_all_i   (cmd_all_i),
    .cmd_chan_i  (cmd_chan_i),
    .set_m_o     (set_m),
    .clr_m_o     (clr_m),
    .inh_m_o     (inh_m),
    .en_m_o      (en_m)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    prot_chan_slice u_slice (
      .clk        (clk),
      .rst        (rst),
      .vtrip_i    (vtrip_i[i]),
      .ctrip_i    (ctrip_i[i]),
      .cc_hold_i  (cc_hold_i),
      .set_i      (set_m[i]),
      .clr_i      (clr_m[i]),
      .inh_i      (inh_m[i]),
      .en_i       (en_m[i]),
      .vflag_n_o  (vflags_n[i]),
      .cflag_n_o  (cflags_n[i]),
      .chan_off_o (chan_off_o[i]),
      .ilim_o     (ilim_o[i])
    );
  end

  prot_status_mux #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_mux (
    .clk         (clk),
    .rst         (rst),
    .sel_chan_i  (sel_chan_i),
    .vflags_n_i  (vflags_n),
    .cflags_n_i  (cflags_n),
    .rmt_vprot_i (rmt_vprot_i),
    .rmt_cprot_i (rmt_cprot_i),
    .vsel_o      (vsel_o),
    .csel_o      (csel_o)
  );

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> ((&chan_off_o) && (ilim_o == '0) && !vsel_o && !csel_o));
  p_all_inhibit_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && cmd_all_i && cmd_op_i == 2'b11) |=> (&chan_off_o));
  p_kill_mode_r8: assert property (@(posedge clk) disable iff (rst)
    (!cc_hold_i) |=> (ilim_o == '0));
endmodule

// File: tb/sim_prot_bank.sv
`timescale 1ns/1ps
module sim_prot_bank;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst;
  logic [5:0] vtrip, ctrip;
  logic       cc_hold, cmd_valid, cmd_all, rmt_v, rmt_c;
  logic [1:0] cmd_op;
  logic [3:0] cmd_chan, sel_chan;
  logic [5:0] chan_off, ilim;
  logic       vsel, csel;

  prot_bank u0 (
    .clk(clk), .rst(rst), .vtrip_i(vtrip), .ctrip_i(ctrip), .cc_hold_i(cc_hold),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_all_i(cmd_all),
    .cmd_chan_i(cmd_chan), .sel_chan_i(sel_chan), .rmt_vprot_i(rmt_v),
    .rmt_cprot_i(rmt_c), .chan_off_o(chan_off), .ilim_o(ilim),
    .vsel_o(vsel), .csel_o(csel)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state built from the requirements
  logic [5:0] mv, mc, mi;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one clocked step with the given trips and command, then compare all outputs
  task automatic go(string req, logic [5:0] vt, logic [5:0] ct, logic valid,
                    logic [1:0] op, logic all, logic [3:0] ch);
    logic [5:0] off_e, ilim_e;
    logic       v_e, c_e;
    vtrip = vt; ctrip = ct; cmd_valid = valid; cmd_op = op;
    cmd_all = all; cmd_chan = ch;
    step();
    for (int i = 0; i < 6; i++) begin
      logic hit;
      hit = valid && (all || ch == 4'(i));
      mv[i] = (mv[i] & ~(hit && op == 2'b00)) | (hit && op == 2'b01) | vt[i];
      mc[i] = (mc[i] & ~(hit && op == 2'b00)) | (hit && op == 2'b01) | ct[i];
      if (hit && op == 2'b11) mi[i] = 1'b1;
      else if (hit && op == 2'b10) mi[i] = 1'b0;
    end
    off_e  = mi | mv | (mc & {6{~cc_hold}});
    ilim_e = mc & ~off_e;
    if (sel_chan < 6) begin v_e = mv[sel_chan]; c_e = mc[sel_chan]; end
    else if (sel_chan < 12) begin v_e = rmt_v; c_e = rmt_c; end
    else begin v_e = 1'b0; c_e = 1'b0; end
    chk({req, " chan_off"}, 32'(chan_off), 32'(off_e));
    chk({req, " ilim"}, 32'(ilim), 32'(ilim_e));
    chk({req, " vsel"}, 32'(vsel), 32'(v_e));
    chk({req, " csel"}, 32'(csel), 32'(c_e));
  endtask

  task automatic idle(string req);
    go(req, 6'h0, 6'h0, 1'b0, 2'b00, 1'b0, 4'd0);
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < 6; i++) begin
      sel_chan = 4'(i);
      idle(req);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    mv = '0; mc = '0; mi = '1;
    chk("R1 chan_off", 32'(chan_off), 32'h3f);
    chk("R1 ilim", 32'(ilim), 32'h0);
    chk("R1 vsel", 32'(vsel), 32'h0);
    chk("R1 csel", 32'(csel), 32'h0);
    rst = 1'b0;
    read_all("R1 flags");
  endtask

  task automatic t_enable();
    cc_hold = 1'b0; sel_chan = 4'd0;
    go("R5 enable all", 6'h0, 6'h0, 1'b1, 2'b10, 1'b1, 4'd9);
    go("R4 inhibit ch3", 6'h0, 6'h0, 1'b1, 2'b11, 1'b0, 4'd3);
    go("R4 enable ch3", 6'h0, 6'h0, 1'b1, 2'b10, 1'b0, 4'd3);
  endtask

  task automatic t_vtrip();
    sel_chan = 4'd2;
    go("R2 vtrip ch2", 6'h04, 6'h0, 1'b0, 2'b00, 1'b0, 4'd0);
    idle("R2 sticky");
    idle("R2 sticky again");
    go("R4 clear ch2", 6'h0, 6'h0, 1'b1, 2'b00, 1'b0, 4'd2);
  endtask

  task automatic t_ctrip();
    cc_hold = 1'b0; sel_chan = 4'd1;
    go("R3 kill ch1", 6'h0, 6'h02, 1'b0, 2'b00, 1'b0, 4'd0);
    go("R4 clear ch1", 6'h0, 6'h0, 1'b1, 2'b00, 1'b0, 4'd1);
    cc_hold = 1'b1;
    go("R3 hold ch1", 6'h0, 6'h02, 1'b0, 2'b00, 1'b0, 4'd0);
    idle("R7 hold stays on");
    cc_hold = 1'b0;
    idle("R8 switch to kill");
    cc_hold = 1'b1;
    idle("R8 switch to hold");
    go("R7 vtrip over hold", 6'h02, 6'h0, 1'b0, 2'b00, 1'b0, 4'd0);
    go("R5 clear all", 6'h0, 6'h0, 1'b1, 2'b00, 1'b1, 4'd0);
    cc_hold = 1'b0;
  endtask

  task automatic t_set_cmds();
    go("R4 set ch5", 6'h0, 6'h0, 1'b1, 2'b01, 1'b0, 4'd5);
    read_all("R4 only ch5 set");
    go("R5 set all", 6'h0, 6'h0, 1'b1, 2'b01, 1'b1, 4'd2);
    read_all("R5 all set");
    go("R5 clear all", 6'h0, 6'h0, 1'b1, 2'b00, 1'b1, 4'd0);
    read_all("R5 all clear");
  endtask

  task automatic t_trip_vs_clear();
    sel_chan = 4'd4;
    go("R6 set ch4", 6'h0, 6'h0, 1'b1, 2'b01, 1'b0, 4'd4);
    go("R6 clear with trips", 6'h10, 6'h10, 1'b1, 2'b00, 1'b0, 4'd4);
    go("R6 clear all with vtrip0", 6'h01, 6'h0, 1'b1, 2'b00, 1'b1, 4'd0);
    read_all("R6 flags after");
    go("R5 clear all", 6'h0, 6'h0, 1'b1, 2'b00, 1'b1, 4'd0);
  endtask

  task automatic t_out_of_range();
    sel_chan = 4'd0;
    go("R11 set ch7", 6'h0, 6'h0, 1'b1, 2'b01, 1'b0, 4'd7);
    go("R11 inhibit ch13", 6'h0, 6'h0, 1'b1, 2'b11, 1'b0, 4'd13);
    read_all("R11 untouched");
  endtask

  task automatic t_status();
    go("R9 set ch3", 6'h0, 6'h0, 1'b1, 2'b01, 1'b0, 4'd3);
    sel_chan = 4'd3; idle("R9 select ch3");
    sel_chan = 4'd0; idle("R9 select ch0");
    sel_chan = 4'd6;  rmt_v = 1'b1; rmt_c = 1'b0; idle("R10 remote 6");
    sel_chan = 4'd11; rmt_v = 1'b0; rmt_c = 1'b1; idle("R10 remote 11");
    sel_chan = 4'd9;  rmt_v = 1'b1; rmt_c = 1'b1; idle("R10 remote 9");
    sel_chan = 4'd12; idle("R10 beyond range 12");
    sel_chan = 4'd15; idle("R10 beyond range 15");
    rmt_v = 1'b0; rmt_c = 1'b0; sel_chan = 4'd3;
    idle("R9 back to ch3");
  endtask

  initial begin
    rst = 1'b1; vtrip = '0; ctrip = '0; cc_hold = 1'b0; cmd_valid = 1'b0;
    cmd_op = 2'b00; cmd_all = 1'b0; cmd_chan = '0; sel_chan = '0;
    rmt_v = 1'b0; rmt_c = 1'b0;
    mv = '0; mc = '0; mi = '1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_vtrip();
    t_ctrip();
    t_set_cmds();
    t_trip_vs_clear();
    t_out_of_range();
    t_status();
    t_reset();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule